// File: doc/BRIEF.md
# Supervisory Reset Controller

This block produces the system reset for a processor. Three requests can start a reset: a digital supply-fail indication from an external voltage comparator, an active-low push-button that is filtered against bounce, and a single-cycle timeout pulse from a watchdog. Power-up is a fourth cause. While any cause is present the reset is held. Once the last cause has cleared, the reset is held for a further fixed number of millisecond ticks before it is released.

A free-running tick, one cycle wide and issued once per millisecond, is the only time base. The push-button line passes through a synchronizer chain. A counter then measures how many consecutive ticks the line stays low. An asynchronous power-on input puts the whole block into the asserted state at once. The reset leaves the block as two registered outputs, one active-high and one active-low, which are always complements of each other.

The stretcher is a three-state machine. HOLD means a cause is present. STRETCH means all causes are gone and the active-time counter is counting down. RUN means the reset is released. The transitions are: CAUSE goes from any state to HOLD and reloads the counter. CLEAR goes from HOLD to STRETCH when no cause is left. EXPIRE goes from STRETCH to RUN on the tick that empties the counter. Power-on reset places the machine in STRETCH with the counter full.

Top module: `reset_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_hi` is 1 and `rst_lo` is 0. Both take these values as soon as `por_n` falls, without waiting for a clock edge.
- R2: `rst_lo` is the complement of `rst_hi` in every cycle.
- R3: If `supply_ok` is 0 at a clock edge, `rst_hi` is 1 after that edge. It stays 1 for as long as `supply_ok` stays 0, whatever the tick does.
- R4: If `wdt_timeout` is 1 at a clock edge, `rst_hi` is 1 after that edge.
- R5: A push-button low that spans fewer than PB_TICKS ticks never asserts reset. Any high sample on the synchronized line clears the count of low ticks.
- R6: When the push-button stays low for PB_TICKS ticks, reset asserts one clock after the edge that samples the PB_TICKS-th tick. It stays asserted while the line remains low.
- R7: After the last cause clears, the reset falls on the edge that samples the ACTIVE_TICKS-th tick of the STRETCH state, and not on any earlier tick.
- R8: Any cause that appears during STRETCH reloads the counter. The full ACTIVE_TICKS ticks are needed again after it clears.
- R9: After `por_n` rises with the supply good, the reset is released after ACTIVE_TICKS ticks. A supply fail during that wait restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ms_tick | input | 1 | One-cycle pulse, once per millisecond |
| supply_ok | input | 1 | 1 when the supply is above the trip level |
| pb_n | input | 1 | Push-button, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| rst_hi | output | 1 | Reset, active high |
| rst_lo | output | 1 | Reset, active low, complement of rst_hi |

## Verification
The bench builds the block with ACTIVE_TICKS = 6 and PB_TICKS = 3. With these values the release point can be checked tick by tick, and every push-button low length from zero ticks up to past saturation can be swept. Each cause is released through the complete stretch count, so the exact release tick, the reload on an overlapping cause and the restart during power-up can all be observed at the outputs.

// File: rtl/reset_supervisor_pkg.sv
package reset_supervisor_pkg;
    typedef enum logic [1:0] {
        SUP_HOLD    = 2'd0,
        SUP_STRETCH = 2'd1,
        SUP_RUN     = 2'd2
    } sup_state_e;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
    parameter int STAGES = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[i] <= RESET_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rsv_pb_filter.sv
module rsv_pb_filter #(
    parameter int PB_TICKS = 10
) (
    input  logic clk,
    input  logic por_n,
    input  logic ms_tick,
    input  logic pb_sync_n,
    output logic pb_req
);
    localparam int CW = $clog2(PB_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(PB_TICKS);

    logic [CW-1:0] low_cnt;

    generate
        if (PB_TICKS < 2 || PB_TICKS > 20) begin : g_bad_range
            $error("PB_TICKS must lie between 2 and 20");
        end
    endgenerate

    // Count consecutive low ticks; any high sample clears; saturate at FULL.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_cnt <= '0;
        end else if (pb_sync_n) begin
            low_cnt <= '0;
        end else if (ms_tick && (low_cnt != FULL)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign pb_req = (low_cnt == FULL);
endmodule

// File: rtl/rsv_stretch_fsm.sv
module rsv_stretch_fsm
    import reset_supervisor_pkg::*;
#(
    parameter int ACTIVE_TICKS = 610
) (
    input  logic clk,
    input  logic por_n,
    input  logic ms_tick,
    input  logic cause,
    output logic rst_hi,
    output logic rst_lo
);
    localparam int CW = $clog2(ACTIVE_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(ACTIVE_TICKS);

    sup_state_e state, nxt;
    logic [CW-1:0] remain;

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            SUP_HOLD:    if (!cause) nxt = SUP_STRETCH;                 // CLEAR
            SUP_STRETCH: if (cause) nxt = SUP_HOLD;                     // CAUSE
                         else if (ms_tick && remain <= 1) nxt = SUP_RUN; // EXPIRE
            SUP_RUN:     if (cause) nxt = SUP_HOLD;                     // CAUSE
            default:     nxt = SUP_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= SUP_STRETCH;
        else        state <= nxt;
    end

    // Active-time counter: reload on any cause, count down in STRETCH
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            remain <= LOAD;
        end else if (cause) begin
            remain <= LOAD;
        end else if (state == SUP_STRETCH && ms_tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_hi <= 1'b1;
            rst_lo <= 1'b0;
        end else begin
            rst_hi <= (nxt != SUP_RUN);
            rst_lo <= (nxt == SUP_RUN);
        end
    end
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
    parameter int ACTIVE_TICKS = 610,
    parameter int PB_TICKS     = 10,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic ms_tick,
    input  logic supply_ok,
    input  logic pb_n,
    input  logic wdt_timeout,
    output logic rst_hi,
    output logic rst_lo
);
    logic pb_sync_n;
    logic pb_req;
    logic cause;

    rsv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   (pb_n),
        .dout  (pb_sync_n)
    );

    rsv_pb_filter #(.PB_TICKS(PB_TICKS)) u_filter (
        .clk       (clk),
        .por_n     (por_n),
        .ms_tick   (ms_tick),
        .pb_sync_n (pb_sync_n),
        .pb_req    (pb_req)
    );

    assign cause = !supply_ok || pb_req || wdt_timeout;

    rsv_stretch_fsm #(.ACTIVE_TICKS(ACTIVE_TICKS)) u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .ms_tick (ms_tick),
        .cause   (cause),
        .rst_hi  (rst_hi),
        .rst_lo  (rst_lo)
    );
endmodule

// File: rtl/reset_supervisor_chk.sv
module reset_supervisor_chk (
    input logic clk,
    input logic por_n,
    input logic ms_tick,
    input logic supply_ok,
    input logic wdt_timeout,
    input logic rst_hi,
    input logic rst_lo
);
    p_por_r1: assert property (@(posedge clk) !por_n |-> (rst_hi && !rst_lo));

    p_compl_r2: assert property (@(posedge clk) disable iff (!por_n)
        rst_hi != rst_lo);

    p_supply_r3: assert property (@(posedge clk) disable iff (!por_n)
        !supply_ok |=> rst_hi);

    p_wdt_r4: assert property (@(posedge clk) disable iff (!por_n)
        wdt_timeout |=> rst_hi);

    p_release_tick_r7: assert property (@(posedge clk) disable iff (!por_n)
        (rst_hi && !ms_tick) |=> rst_hi);

    p_release_ok_r9: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_hi) |-> $past(supply_ok));
endmodule

bind reset_supervisor reset_supervisor_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .ms_tick     (ms_tick),
    .supply_ok   (supply_ok),
    .wdt_timeout (wdt_timeout),
    .rst_hi      (rst_hi),
    .rst_lo      (rst_lo)
);

// File: tb/sim_reset_supervisor.sv
module sim_reset_supervisor;
    localparam int A = 6;
    localparam int P = 3;

    logic clk = 1'b0;
    logic por_n = 1'b1;
    logic ms_tick = 1'b0;
    logic supply_ok = 1'b1;
    logic pb_n = 1'b1;
    logic wdt_timeout = 1'b0;
    logic rst_hi, rst_lo;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    reset_supervisor #(.ACTIVE_TICKS(A), .PB_TICKS(P), .SYNC_STAGES(2)) u0 (
        .clk(clk), .por_n(por_n), .ms_tick(ms_tick), .supply_ok(supply_ok),
        .pb_n(pb_n), .wdt_timeout(wdt_timeout), .rst_hi(rst_hi), .rst_lo(rst_lo)
    );

    task automatic chk(input logic exp, input string tag);
        n_run++;
        if (rst_hi !== exp || rst_lo !== ~exp) begin
            n_fail++;
            $display("FAIL %s: rst_hi=%b rst_lo=%b expected rst_hi=%b rst_lo=%b",
                     tag, rst_hi, rst_lo, exp, ~exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    // Release count after causes clear: R7
    task automatic release_sweep(input string tag);
        for (int k = 1; k <= A; k++) begin
            tick();
            chk((k < A) ? 1'b1 : 1'b0, tag);
        end
    endtask

    initial begin
        #1 por_n = 1'b0;
        idle(3);
        chk(1'b1, "R1 reset state");
        por_n = 1'b1;
        idle(2);
        release_sweep("R9 power-up release");

        // R3 supply fail
        supply_ok = 1'b0;
        idle(1);
        chk(1'b1, "R3 supply fail asserts");
        for (int k = 0; k < A + 2; k++) begin
            tick();
            chk(1'b1, "R3 held while supply low");
        end
        supply_ok = 1'b1;
        idle(2);
        release_sweep("R7 release after supply");

        // R4 watchdog
        wdt_timeout = 1'b1;
        @(negedge clk) wdt_timeout = 1'b0;
        chk(1'b1, "R4 watchdog asserts");
        idle(2);
        release_sweep("R7 release after watchdog");

        // R5 / R6 push-button length sweep
        for (int n = 0; n <= P + 2; n++) begin
            pb_n = 1'b0;
            idle(3);
            for (int i = 1; i <= n; i++) begin
                tick();
                if (i == P) chk(1'b0, "R6 one-cycle latency");
            end
            idle(1);
            if (n >= P) chk(1'b1, "R6 long press resets");
            else        chk(1'b0, "R5 short press ignored");
            pb_n = 1'b1;
            idle(4);
            if (n >= P) release_sweep("R7 release after button");
            else        chk(1'b0, "R5 no reset after short press");
        end

        // R5 high sample clears the count
        pb_n = 1'b0;
        idle(3);
        for (int i = 0; i < P - 1; i++) tick();
        pb_n = 1'b1;
        idle(4);
        pb_n = 1'b0;
        idle(3);
        for (int i = 0; i < P - 1; i++) tick();
        idle(1);
        chk(1'b0, "R5 count cleared by high");
        pb_n = 1'b1;
        idle(4);

        // R8 reload during stretch
        supply_ok = 1'b0;
        idle(1);
        supply_ok = 1'b1;
        idle(2);
        for (int i = 0; i < 3; i++) tick();
        wdt_timeout = 1'b1;
        @(negedge clk) wdt_timeout = 1'b0;
        idle(1);
        for (int k = 1; k < A; k++) begin
            tick();
            chk(1'b1, "R8 reload extends pulse");
        end
        tick();
        chk(1'b0, "R8 release after full reload");

        // R1 asynchronous mid-run, R9 restart on supply fail
        @(negedge clk);
        #1 por_n = 1'b0;
        #0.5 chk(1'b1, "R1 asynchronous assert");
        idle(2);
        por_n = 1'b1;
        idle(1);
        tick();
        tick();
        chk(1'b1, "R9 still held during power-up");
        supply_ok = 1'b0;
        idle(1);
        supply_ok = 1'b1;
        idle(2);
        release_sweep("R9 restart after supply fail");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule